// File: doc/BRIEF.md
# Backplane Link Bring-up Sequencer

This block is the top-level controller that takes a backplane Ethernet port from power-up to a usable data link. After reset it walks through an initialization step, auto-negotiation, link training and data-mode reconfiguration. In data mode it watches two lock indications. The PHY reconfiguration, the negotiation and training engines and the PCS all sit outside the block. The sequencer only sees their status flags and a one-cycle reconfiguration-complete handshake, and it drives a reconfiguration request for each mode, a transmitter-disable level, a link-ready flag and its current state code.

All durations are measured by millisecond timers inside the block. Each timer divides the clock by a cycles-per-millisecond parameter, so a simulation can run with a tiny value. The link is declared ready only after both lock flags have held together for a qualified period. A watchdog sends the port back to initialization when data mode is not reached in time. A brief loss of lock in data mode is tolerated for a fixed grace window before the block decides between recovery and a full restart.

Top module: `link_bringup_seq`

## Requirements
- R1: During reset state_code is 0 (INIT) and every request, tx_disable and link_ready are low. INIT lasts exactly one cycle and is then left.
- R2: state_code encodes INIT=0, RC_AN=1, AN_ABL=2, AN_CHK=3, RC_LT=4, LT_CHK=5, RC_DATA=6, DATA_CHK=7, LNK_RDY=8, LR_WAIT=9. With an_ena high, INIT goes to RC_AN. Each RC_* state waits for a one-cycle reconfig_done and then advances (RC_AN to AN_ABL, RC_LT to LT_CHK, RC_DATA to DATA_CHK).
- R3: rc_an_req, rc_lt_req and rc_data_req are each a single-cycle pulse that is high in the first cycle of RC_AN, RC_LT and RC_DATA respectively.
- R4: AN_ABL lasts exactly ABL_MS*CYC_PER_MS cycles, then goes to AN_CHK, and tx_disable is high for exactly those cycles. ABL_MS is the AN_ABL_MS parameter clamped to the range 60 to 75.
- R5: AN_CHK holds while an_done is 0. One cycle after an_done is 1 the block is in RC_LT, or in RC_DATA when lt_ena is 0.
- R6: LT_CHK holds while local_rx_ready is 0. One cycle after local_rx_ready is 1 the block is in RC_DATA.
- R7: From INIT with an_ena low, the next state is RC_LT when lt_ena is high and RC_DATA when lt_ena is low.
- R8: DATA_CHK moves to LNK_RDY after rx_lock and cdr_lock have been high together for QUAL_MS*CYC_PER_MS consecutive cycles. A single cycle with either flag low restarts the count from zero.
- R9: The watchdog starts when RC_LT is entered, or when RC_DATA is entered while training is skipped. If it runs for WD_MS*CYC_PER_MS cycles while the block is still in RC_LT, LT_CHK, RC_DATA or DATA_CHK, the block returns to INIT.
- R10: link_ready is high only in LNK_RDY. A cycle in LNK_RDY with either lock flag low moves the block to LR_WAIT.
- R11: LR_WAIT lasts exactly LR_WAIT_CYC cycles. In its last cycle, both lock flags high send the block to LNK_RDY; otherwise the block goes to INIT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| an_ena | input | 1 | Auto-negotiation enable strap |
| lt_ena | input | 1 | Link-training enable strap |
| an_done | input | 1 | Negotiation engine reports completion |
| local_rx_ready | input | 1 | Training engine reports local receiver trained |
| rx_lock | input | 1 | Data-ready or multi-lane deskew lock flag |
| cdr_lock | input | 1 | Clock-data recovery locked to data |
| reconfig_done | input | 1 | One-cycle completion of the requested PHY reconfiguration |
| state_code | output | 4 | Current state, encoded as in R2 |
| rc_an_req | output | 1 | Pulse requesting reconfiguration for negotiation |
| rc_lt_req | output | 1 | Pulse requesting reconfiguration for training |
| rc_data_req | output | 1 | Pulse requesting reconfiguration for data mode |
| tx_disable | output | 1 | Transmitter held quiet during AN_ABL |
| link_ready | output | 1 | Link is up in data mode |

## Verification
The hardest situations to reach are the two long-window exits: the watchdog firing while the lock qualification keeps restarting, and the qualification restarting after one broken cycle late in its count. The bench shrinks the millisecond to ten cycles. It then holds lock high for most of the qualification window, breaks it for exactly one cycle and counts the cycles to LNK_RDY from the restart. For the watchdog, it toggles cdr_lock in runs shorter than the window, so DATA_CHK can never qualify and the watchdog has to be the exit.

// File: rtl/lbs_pkg.sv
package lbs_pkg;
   typedef enum logic [3:0] {
      ST_INIT     = 4'd0,
      ST_RC_AN    = 4'd1,
      ST_AN_ABL   = 4'd2,
      ST_AN_CHK   = 4'd3,
      ST_RC_LT    = 4'd4,
      ST_LT_CHK   = 4'd5,
      ST_RC_DATA  = 4'd6,
      ST_DATA_CHK = 4'd7,
      ST_LNK_RDY  = 4'd8,
      ST_LR_WAIT  = 4'd9
   } lbs_state_e;
endpackage

// File: rtl/lbs_ms_timer.sv
module lbs_ms_timer #(
   parameter int CYC_PER_MS = 125000,
   parameter int MS_W       = 10
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clr,
   output logic [MS_W-1:0] ms,
   output logic            tick
);
   localparam int SUB_W = (CYC_PER_MS > 1) ? $clog2(CYC_PER_MS) : 1;

   generate
      if (CYC_PER_MS < 1) begin : g_bad_div
         $error("lbs_ms_timer: CYC_PER_MS must be at least 1");
      end
      if (CYC_PER_MS == 1) begin : g_unit
         assign tick = 1'b1;
      end else begin : g_div
         logic [SUB_W-1:0] sub;
         assign tick = (sub == SUB_W'(CYC_PER_MS - 1));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)           sub <= '0;
            else if (clr || tick) sub <= '0;
            else                  sub <= sub + 1'b1;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   ms <= '0;
      else if (clr)                 ms <= '0;
      else if (tick && (ms != '1))  ms <= ms + 1'b1;
   end

   // R9
   ms_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> ((ms == $past(ms)) || (ms == $past(ms) + 1'b1)));
endmodule

// File: rtl/lbs_lock_qual.sv
module lbs_lock_qual #(
   parameter int QUAL_CYC = 125000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   input  logic lock_a,
   input  logic lock_b,
   output logic qualified
);
   localparam int CW = $clog2(QUAL_CYC + 1);
   localparam logic [CW-1:0] LAST = CW'(QUAL_CYC - 1);

   logic [CW-1:0] run;
   logic          ok;

   assign ok        = arm && lock_a && lock_b;
   assign qualified = ok && (run == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            run <= '0;
      else if (!ok)          run <= '0;
      else if (run != LAST)  run <= run + 1'b1;
   end

   generate
      if (QUAL_CYC < 1) begin : g_bad_qual
         $error("lbs_lock_qual: QUAL_CYC must be at least 1");
      end
      if (QUAL_CYC > 1) begin : g_chk
         // R8
         qual_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (arm && !(lock_a && lock_b)) |=> !qualified);
      end
   endgenerate
endmodule

// File: rtl/link_bringup_seq.sv
module link_bringup_seq
   import lbs_pkg::*;
#(
   parameter int CYC_PER_MS  = 125000,
   parameter int AN_ABL_MS   = 65,
   parameter int WD_MS       = 500,
   parameter int QUAL_MS     = 1,
   parameter int LR_WAIT_CYC = 1000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       an_ena,
   input  logic       lt_ena,
   input  logic       an_done,
   input  logic       local_rx_ready,
   input  logic       rx_lock,
   input  logic       cdr_lock,
   input  logic       reconfig_done,
   output logic [3:0] state_code,
   output logic       rc_an_req,
   output logic       rc_lt_req,
   output logic       rc_data_req,
   output logic       tx_disable,
   output logic       link_ready
);
   localparam int ABL_MS   = (AN_ABL_MS < 60) ? 60 : ((AN_ABL_MS > 75) ? 75 : AN_ABL_MS);
   localparam int ST_MS_W  = $clog2(ABL_MS + 1);
   localparam int WD_MS_W  = $clog2(WD_MS + 1);
   localparam int QUAL_CYC = QUAL_MS * CYC_PER_MS;
   localparam int LR_W     = $clog2(LR_WAIT_CYC + 1);

   generate
      if (CYC_PER_MS < 1) begin : g_bad_cyc
         $error("link_bringup_seq: CYC_PER_MS must be at least 1");
      end
      if (WD_MS < 2 || QUAL_MS < 1 || QUAL_MS >= WD_MS) begin : g_bad_ms
         $error("link_bringup_seq: need 1 <= QUAL_MS < WD_MS and WD_MS >= 2");
      end
      if (LR_WAIT_CYC < 1) begin : g_bad_lr
         $error("link_bringup_seq: LR_WAIT_CYC must be at least 1");
      end
   endgenerate

   lbs_state_e st, nxt;

   logic               lock_ok;
   logic [ST_MS_W-1:0] st_ms;
   logic               st_tick;
   logic [WD_MS_W-1:0] wd_ms;
   logic               wd_tick;
   logic               wd_clr, wd_arm, wd_exp;
   logic               abl_end;
   logic               qualified;
   logic [LR_W-1:0]    lr_cnt;
   logic               lr_end;

   assign lock_ok = rx_lock && cdr_lock;

   // state-duration timer restarts on every state change
   lbs_ms_timer #(.CYC_PER_MS(CYC_PER_MS), .MS_W(ST_MS_W)) u_st_tmr (
      .clk(clk), .rst_n(rst_n), .clr(nxt != st), .ms(st_ms), .tick(st_tick));

   // watchdog timer restarts when the post-negotiation phase begins
   assign wd_clr = ((nxt == ST_RC_LT) && (st != ST_RC_LT)) ||
                   ((nxt == ST_RC_DATA) && (st != ST_RC_DATA) && (st != ST_LT_CHK));

   lbs_ms_timer #(.CYC_PER_MS(CYC_PER_MS), .MS_W(WD_MS_W)) u_wd_tmr (
      .clk(clk), .rst_n(rst_n), .clr(wd_clr), .ms(wd_ms), .tick(wd_tick));

   lbs_lock_qual #(.QUAL_CYC(QUAL_CYC)) u_qual (
      .clk(clk), .rst_n(rst_n), .arm(st == ST_DATA_CHK),
      .lock_a(rx_lock), .lock_b(cdr_lock), .qualified(qualified));

   assign abl_end = (st_ms == ST_MS_W'(ABL_MS - 1)) && st_tick;
   assign wd_arm  = (st == ST_RC_LT) || (st == ST_LT_CHK) ||
                    (st == ST_RC_DATA) || (st == ST_DATA_CHK);
   assign wd_exp  = wd_arm && (wd_ms == WD_MS_W'(WD_MS - 1)) && wd_tick;
   assign lr_end  = (lr_cnt == LR_W'(LR_WAIT_CYC - 1));

   always_comb begin
      nxt = st;
      case (st)
         ST_INIT:     nxt = an_ena ? ST_RC_AN : (lt_ena ? ST_RC_LT : ST_RC_DATA);
         ST_RC_AN:    if (reconfig_done) nxt = ST_AN_ABL;
         ST_AN_ABL:   if (abl_end) nxt = ST_AN_CHK;
         ST_AN_CHK:   if (an_done) nxt = lt_ena ? ST_RC_LT : ST_RC_DATA;
         ST_RC_LT:    if (wd_exp) nxt = ST_INIT;
                      else if (reconfig_done) nxt = ST_LT_CHK;
         ST_LT_CHK:   if (wd_exp) nxt = ST_INIT;
                      else if (local_rx_ready) nxt = ST_RC_DATA;
         ST_RC_DATA:  if (wd_exp) nxt = ST_INIT;
                      else if (reconfig_done) nxt = ST_DATA_CHK;
         ST_DATA_CHK: if (qualified) nxt = ST_LNK_RDY;
                      else if (wd_exp) nxt = ST_INIT;
         ST_LNK_RDY:  if (!lock_ok) nxt = ST_LR_WAIT;
         ST_LR_WAIT:  if (lr_end) nxt = lock_ok ? ST_LNK_RDY : ST_INIT;
         default:     nxt = ST_INIT;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st          <= ST_INIT;
         rc_an_req   <= 1'b0;
         rc_lt_req   <= 1'b0;
         rc_data_req <= 1'b0;
         lr_cnt      <= '0;
      end else begin
         st          <= nxt;
         rc_an_req   <= (nxt == ST_RC_AN)   && (st != ST_RC_AN);
         rc_lt_req   <= (nxt == ST_RC_LT)   && (st != ST_RC_LT);
         rc_data_req <= (nxt == ST_RC_DATA) && (st != ST_RC_DATA);
         lr_cnt      <= (st == ST_LR_WAIT) ? lr_cnt + 1'b1 : '0;
      end
   end

   assign state_code = st;
   assign tx_disable = (st == ST_AN_ABL);
   assign link_ready = (st == ST_LNK_RDY);

   // R3
   req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rc_an_req || rc_lt_req || rc_data_req) |=> !(rc_an_req || rc_lt_req || rc_data_req));
   // R4
   txdis_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_disable) |-> ($past(state_code) == ST_RC_AN) && $past(reconfig_done));
   // R5
   an_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(state_code) == ST_AN_CHK) && (state_code != ST_AN_CHK)) |-> $past(an_done));
   // R6
   lt_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(state_code) == ST_LT_CHK) && (state_code == ST_RC_DATA)) |-> $past(local_rx_ready));
   // R10
   lrwait_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_code == ST_LR_WAIT) && ($past(state_code) != ST_LR_WAIT)) |->
      (($past(state_code) == ST_LNK_RDY) && !$past(rx_lock && cdr_lock)));
   // R11
   lr_recover_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(state_code) == ST_LR_WAIT) && link_ready) |-> $past(rx_lock && cdr_lock));
endmodule

// File: tb/link_bringup_seq_test.sv
module link_bringup_seq_test;
   localparam int CYC  = 10;
   localparam int ABL  = 65 * CYC;
   localparam int ABLC = 75 * CYC;
   localparam int WDC  = 500 * CYC;
   localparam int LRW  = 20;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic an_ena = 1'b1, lt_ena = 1'b1, an_done = 1'b0, local_rx_ready = 1'b0;
   logic rx_lock = 1'b0, cdr_lock = 1'b0, reconfig_done = 1'b0;
   logic [3:0] state_code;
   logic rc_an_req, rc_lt_req, rc_data_req, tx_disable, link_ready;
   logic [3:0] c_state;
   logic c_an, c_lt, c_data, c_tx, c_rdy;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;
   int c_run = 0;
   int c_len = 0;

   always #4 clk = ~clk;

   link_bringup_seq #(.CYC_PER_MS(CYC), .AN_ABL_MS(65), .WD_MS(500),
                      .QUAL_MS(1), .LR_WAIT_CYC(LRW)) uut (
      .clk(clk), .rst_n(rst_n), .an_ena(an_ena), .lt_ena(lt_ena), .an_done(an_done),
      .local_rx_ready(local_rx_ready), .rx_lock(rx_lock), .cdr_lock(cdr_lock),
      .reconfig_done(reconfig_done), .state_code(state_code), .rc_an_req(rc_an_req),
      .rc_lt_req(rc_lt_req), .rc_data_req(rc_data_req), .tx_disable(tx_disable),
      .link_ready(link_ready));

   // second instance: negotiation quiet time asked above the legal range
   link_bringup_seq #(.CYC_PER_MS(CYC), .AN_ABL_MS(90), .WD_MS(500),
                      .QUAL_MS(1), .LR_WAIT_CYC(LRW)) uut_clamp (
      .clk(clk), .rst_n(rst_n), .an_ena(an_ena), .lt_ena(lt_ena), .an_done(an_done),
      .local_rx_ready(local_rx_ready), .rx_lock(rx_lock), .cdr_lock(cdr_lock),
      .reconfig_done(reconfig_done), .state_code(c_state), .rc_an_req(c_an),
      .rc_lt_req(c_lt), .rc_data_req(c_data), .tx_disable(c_tx), .link_ready(c_rdy));

   always @(negedge clk) begin
      if (c_tx) c_run++;
      else if (c_run != 0) begin
         c_len = c_run;
         c_run = 0;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic pulse_rc();
      reconfig_done = 1'b1;
      step();
      reconfig_done = 1'b0;
   endtask

   task automatic count_in(input int s, output int n);
      n = 0;
      while (state_code == 4'(s) && n < 20000) begin
         n++;
         step();
      end
   endtask

   task automatic do_reset(input logic a, input logic l);
      rst_n = 1'b0;
      an_ena = a;
      lt_ena = l;
      repeat (3) step();
      rst_n = 1'b1;
      step();
   endtask

   task automatic summary();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: run did not finish actual=0 expected=1");
      summary();
      $finish;
   end

   initial begin
      int n;
      repeat (3) step();
      // R1 reset state
      chk(state_code == 4'd0, "R1 reset state", state_code, 0);
      chk({rc_an_req, rc_lt_req, rc_data_req, tx_disable, link_ready} == 5'b0,
          "R1 reset outputs", {rc_an_req, rc_lt_req, rc_data_req, tx_disable, link_ready}, 0);
      rst_n = 1'b1;
      step();
      // R2 INIT leaves after one cycle, R3 request pulse
      chk(state_code == 4'd1, "R2 init to RC_AN", state_code, 1);
      chk(rc_an_req == 1'b1, "R3 rc_an_req first cycle", rc_an_req, 1);
      step();
      chk(rc_an_req == 1'b0 && state_code == 4'd1, "R3 rc_an_req single pulse", rc_an_req, 0);
      pulse_rc();
      chk(state_code == 4'd2 && tx_disable, "R2 RC_AN to AN_ABL", state_code, 2);
      count_in(2, n);
      chk(n == ABL, "R4 AN_ABL length", n, ABL);
      chk(state_code == 4'd3 && !tx_disable, "R4 AN_ABL to AN_CHK", state_code, 3);
      repeat (120) step();
      chk(state_code == 4'd3, "R5 AN_CHK holds without an_done", state_code, 3);
      repeat (40) step();
      chk(c_len == ABLC, "R4 clamped AN_ABL length", c_len, ABLC);
      an_done = 1'b1;
      step();
      an_done = 1'b0;
      chk(state_code == 4'd4 && rc_lt_req, "R5 AN_CHK to RC_LT", state_code, 4);
      pulse_rc();
      chk(state_code == 4'd5, "R2 RC_LT to LT_CHK", state_code, 5);
      repeat (20) step();
      chk(state_code == 4'd5, "R6 LT_CHK holds", state_code, 5);
      local_rx_ready = 1'b1;
      step();
      local_rx_ready = 1'b0;
      chk(state_code == 4'd6 && rc_data_req, "R6 LT_CHK to RC_DATA", state_code, 6);
      pulse_rc();
      chk(state_code == 4'd7, "R2 RC_DATA to DATA_CHK", state_code, 7);
      // R8 qualification with a one-cycle break
      rx_lock = 1'b1;
      cdr_lock = 1'b1;
      repeat (7) step();
      cdr_lock = 1'b0;
      step();
      cdr_lock = 1'b1;
      repeat (9) step();
      chk(state_code == 4'd7, "R8 not yet qualified after restart", state_code, 7);
      step();
      chk(state_code == 4'd8 && link_ready, "R8 qualified after full window", state_code, 8);
      // R10/R11 short loss then recovery
      rx_lock = 1'b0;
      step();
      chk(state_code == 4'd9 && !link_ready, "R10 lock loss to LR_WAIT", state_code, 9);
      rx_lock = 1'b1;
      count_in(9, n);
      chk(n == LRW, "R11 LR_WAIT length", n, LRW);
      chk(state_code == 4'd8 && link_ready, "R11 recovery to LNK_RDY", state_code, 8);
      // R11 loss persists, restart
      cdr_lock = 1'b0;
      step();
      count_in(9, n);
      chk(n == LRW, "R11 LR_WAIT length before restart", n, LRW);
      chk(state_code == 4'd0, "R11 restart to INIT", state_code, 0);
      step();
      chk(state_code == 4'd1, "R1 INIT lasts one cycle", state_code, 1);
      // R9 watchdog from RC_LT with training never finishing
      rx_lock = 1'b0;
      pulse_rc();
      count_in(2, n);
      an_done = 1'b1;
      step();
      an_done = 1'b0;
      n = 0;
      while (state_code >= 4'd4 && state_code <= 4'd7 && n < 20000) begin
         reconfig_done = (state_code == 4'd4);
         n++;
         step();
      end
      reconfig_done = 1'b0;
      chk(n == WDC, "R9 watchdog from RC_LT", n, WDC);
      chk(state_code == 4'd0, "R9 watchdog returns to INIT", state_code, 0);
      // R7 skip both, R9 watchdog from RC_DATA with flickering lock
      do_reset(1'b0, 1'b0);
      chk(state_code == 4'd6 && rc_data_req, "R7 skip to RC_DATA", state_code, 6);
      rx_lock = 1'b1;
      n = 0;
      while (state_code >= 4'd6 && state_code <= 4'd7 && n < 20000) begin
         reconfig_done = (state_code == 4'd6);
         cdr_lock = ((n % 8) < 5);
         n++;
         step();
      end
      reconfig_done = 1'b0;
      chk(n == WDC, "R9 watchdog in DATA_CHK", n, WDC);
      chk(state_code == 4'd0, "R9 DATA_CHK watchdog to INIT", state_code, 0);
      // R7 skip negotiation only
      do_reset(1'b0, 1'b1);
      chk(state_code == 4'd4 && rc_lt_req, "R7 skip to RC_LT", state_code, 4);
      // R5 negotiation without training
      do_reset(1'b1, 1'b0);
      pulse_rc();
      count_in(2, n);
      an_done = 1'b1;
      step();
      an_done = 1'b0;
      chk(state_code == 4'd6 && rc_data_req, "R5 AN_CHK to RC_DATA when training off", state_code, 6);
      summary();
      $finish;
   end
endmodule